// File: doc/BRIEF.md
# Configurable Frame Serial Transmitter

This block drives one asynchronous serial line. When a byte is offered on a valid/ready handshake, the block takes that byte together with the format settings present on its inputs in the same cycle. From them it builds the whole frame as one word: a low start bit, 5 to 8 data bits sent least significant first, an optional parity bit and one or two high stop bits. It then sends that word one bit per bit period, where the bit period is a count of clock cycles.

Parity can be even, odd, forced high (mark) or forced low (space). An invert flag complements every bit of the frame and also the resting level of the line. The ready output stays low for the whole frame. A one-cycle done pulse marks the point where the last stop bit has been held for a full period. Receive logic, buffering and baud-rate derivation belong to other blocks.

Top module: `uart_frame_tx`

## Requirements
- R1: The frame begins with a start bit of value 0, followed by the data bits least significant first; `cfg_data_bits` values 5, 6, 7 and 8 select that many data bits, and any other value selects 8.
- R2: `cfg_parity` encodes 0 = none, 1 = even, 2 = odd, 3 = mark (always 1), 4 = space (always 0); values 5 to 7 select none. Even parity is the XOR of the configured data bits only, odd is its inverse, and the parity bit is sent directly after the last data bit.
- R3: Stop bits of value 1 end the frame: `cfg_stop_bits` = 2 selects two, and any other value selects one.
- R4: With `cfg_invert` = 1 at acceptance, every bit of the frame (start, data, parity, stop) is complemented on `tx_line`.
- R5: While no frame is in progress, `tx_line` rests at 1, or at 0 when `cfg_invert` is 1. The line follows a change of `cfg_invert` at the next clock edge.
- R6: The first frame bit appears on `tx_line` at the clock edge that accepts the byte. Each bit is held for `bit_period` cycles, and a `bit_period` of 0 is treated as 1.
- R7: `in_ready` goes low at acceptance and returns high at the edge where the last stop bit has been held for a full period. At that same edge `tx_done` goes high for exactly one cycle, and `tx_line` returns to its resting level.
- R8: Data, format settings and bit period are captured at acceptance. Changing them, or holding `in_valid` high, while a frame is in progress has no effect on that frame.
- R9: During and after reset `tx_line` is 1, `in_ready` is 1 and `tx_done` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_data | input | 8 | Byte to send |
| in_valid | input | 1 | Byte offered |
| in_ready | output | 1 | High when a byte can be accepted |
| bit_period | input | PERIOD_W | Clock cycles per bit (0 acts as 1) |
| cfg_data_bits | input | 4 | Data bit count, 5 to 8 |
| cfg_parity | input | 3 | Parity mode code |
| cfg_stop_bits | input | 2 | Stop bit count, 1 or 2 |
| cfg_invert | input | 1 | Complement frame and idle level |
| tx_line | output | 1 | Serial output |
| tx_done | output | 1 | One-cycle pulse at frame end |

## Verification
The bench goes after parity taken over a 5-bit field when the byte has set bits above that field. A design that XORs the full byte would send the wrong parity bit there. It drives unrecognised codes for every format field: a decoder with the wrong default would change the frame length, and the done pulse would then arrive a whole number of bit periods early or late. Other cases are inverted frames with the changed idle level, a zero bit period, and settings that change while a frame is in progress. A design that reads its inputs live instead of latching them would corrupt the remaining bits of that frame. The bench also holds the ready and done timing to the exact cycle, so a timer that is off by one shows up on the first frame.

// File: rtl/uft_pkg.sv
// Shared types and decode helpers for the frame transmitter.
// Assumes at most 8 data bits, one parity bit and two stop bits per frame.
package uft_pkg;

    localparam int MAX_DATA = 8;
    localparam int FRAME_W  = 1 + MAX_DATA + 1 + 2;
    localparam int CNT_W    = $clog2(FRAME_W + 1);

    typedef enum logic [2:0] {
        PAR_NONE  = 3'd0,
        PAR_EVEN  = 3'd1,
        PAR_ODD   = 3'd2,
        PAR_MARK  = 3'd3,
        PAR_SPACE = 3'd4
    } parity_e;

    typedef struct packed {
        logic [3:0] dbits;     // resolved data bit count, 5..8
        parity_e    par;       // resolved parity mode
        logic       two_stop;  // 1 = two stop bits
        logic       invert;    // complement whole frame
    } frame_fmt_t;

endpackage

// File: rtl/uft_cfg_decode.sv
// Resolves raw format codes into a legal frame format.
// Unknown data-bit counts fall back to 8, unknown parity codes to none,
// and unknown stop codes to one stop bit. Purely combinational.
module uft_cfg_decode
    import uft_pkg::*;
(
    input  logic [3:0]  raw_dbits,
    input  logic [2:0]  raw_parity,
    input  logic [1:0]  raw_stop,
    input  logic        raw_invert,
    output frame_fmt_t  fmt
);

    // Map each raw field onto its resolved value.
    always_comb begin
        fmt = '0;
        case (raw_dbits)
            4'd5, 4'd6, 4'd7, 4'd8: fmt.dbits = raw_dbits;
            default:                fmt.dbits = 4'd8;
        endcase
        case (raw_parity)
            3'd1:    fmt.par = PAR_EVEN;
            3'd2:    fmt.par = PAR_ODD;
            3'd3:    fmt.par = PAR_MARK;
            3'd4:    fmt.par = PAR_SPACE;
            default: fmt.par = PAR_NONE;
        endcase
        fmt.two_stop = (raw_stop == 2'd2);
        fmt.invert   = raw_invert;
    end

endmodule

// File: rtl/uft_frame_builder.sv
// Assembles the full frame word from a byte and a resolved format.
// Bit 0 is the start bit; data, optional parity and stop bits follow.
// Positions above the frame length are don't-care. Combinational.
module uft_frame_builder
    import uft_pkg::*;
(
    input  logic [MAX_DATA-1:0] data,
    input  frame_fmt_t          fmt,
    output logic [FRAME_W-1:0]  word,
    output logic [CNT_W-1:0]    len
);

    logic [MAX_DATA-1:0] used;
    logic                xsum;
    logic                pbit;
    logic                has_par;
    logic [CNT_W-1:0]    pos;

    // Keep only the configured data bits and fold them into a parity sum.
    always_comb begin
        used = '0;
        for (int i = 0; i < MAX_DATA; i++) begin
            if (i < int'(fmt.dbits)) begin
                used[i] = data[i];
            end
        end
        xsum = ^used;
    end

    // Pick the parity bit value for the selected mode.
    always_comb begin
        has_par = (fmt.par != PAR_NONE);
        case (fmt.par)
            PAR_EVEN:  pbit = xsum;
            PAR_ODD:   pbit = ~xsum;
            PAR_MARK:  pbit = 1'b1;
            default:   pbit = 1'b0;
        endcase
    end

    // Place start, data, parity and stop bits, then apply inversion.
    always_comb begin
        word = '0;
        word[MAX_DATA:1] = used;
        pos = CNT_W'(1) + CNT_W'(fmt.dbits);
        if (has_par) begin
            word[pos] = pbit;
            pos = pos + CNT_W'(1);
        end
        word[pos] = 1'b1;
        if (fmt.two_stop) begin
            word[pos + CNT_W'(1)] = 1'b1;
            len = pos + CNT_W'(2);
        end else begin
            len = pos + CNT_W'(1);
        end
        word = word ^ {FRAME_W{fmt.invert}};
    end

endmodule

// File: rtl/uft_bit_timer.sv
// Counts clock cycles within one bit period and flags its last cycle.
// Assumes load is only raised when no frame is in progress; a period of 0
// is treated as 1.
module uft_bit_timer #(
    parameter int PERIOD_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [PERIOD_W-1:0] period,
    input  logic                busy,
    output logic                tick
);

    logic [PERIOD_W-1:0] reload_q;
    logic [PERIOD_W-1:0] cnt_q;
    logic [PERIOD_W-1:0] period_m1;

    // Derive the reload value, guarding against a zero period.
    always_comb begin
        period_m1 = (period == '0) ? '0 : period - PERIOD_W'(1);
    end

    // Count down each bit period and restart from the latched reload value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload_q <= '0;
            cnt_q    <= '0;
        end else if (load) begin
            reload_q <= period_m1;
            cnt_q    <= period_m1;
        end else if (busy) begin
            if (cnt_q == '0) begin
                cnt_q <= reload_q;
            end else begin
                cnt_q <= cnt_q - PERIOD_W'(1);
            end
        end
    end

    assign tick = busy && (cnt_q == '0);

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cnt_q <= reload_q)); // R6

    AST_RELOAD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !load) |=> $stable(reload_q)); // R8

endmodule

// File: rtl/uft_shifter.sv
// Holds the frame word and drives the line one bit at a time.
// Assumes load only while idle and tick only while busy. Drives the
// resting level whenever no frame is in progress.
module uft_shifter
    import uft_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [FRAME_W-1:0] frame,
    input  logic [CNT_W-1:0]   len,
    input  logic               tick,
    input  logic               idle_level,
    output logic               tx,
    output logic               busy,
    output logic               done
);

    logic [FRAME_W-1:0] shreg_q;
    logic [CNT_W-1:0]   left_q;

    // Load a frame, step through its bits on each tick, rest when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx      <= 1'b1;
            busy    <= 1'b0;
            done    <= 1'b0;
            shreg_q <= '0;
            left_q  <= '0;
        end else begin
            done <= 1'b0;
            if (load) begin
                tx      <= frame[0];
                shreg_q <= frame >> 1;
                left_q  <= len;
                busy    <= 1'b1;
            end else if (tick) begin
                if (left_q == CNT_W'(1)) begin
                    busy   <= 1'b0;
                    done   <= 1'b1;
                    tx     <= idle_level;
                    left_q <= '0;
                end else begin
                    tx      <= shreg_q[0];
                    shreg_q <= shreg_q >> 1;
                    left_q  <= left_q - CNT_W'(1);
                end
            end else if (!busy) begin
                tx <= idle_level;
            end
        end
    end

    AST_LEFT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (left_q != '0)); // R7

    AST_LAST_BIT_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && left_q == CNT_W'(1)) |=> (done && !busy)); // R7

    AST_HOLD_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tick) |=> $stable(tx)); // R6

    AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !load) |=> (tx == $past(idle_level))); // R5

endmodule

// File: rtl/uart_frame_tx.sv
// Top of the serial transmitter: accepts a byte on valid/ready, captures
// the format and period, and sends the assembled frame on tx_line.
// Assumes the format inputs are meaningful in the accepting cycle only.
module uart_frame_tx
    import uft_pkg::*;
#(
    parameter int PERIOD_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [7:0]          in_data,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [PERIOD_W-1:0] bit_period,
    input  logic [3:0]          cfg_data_bits,
    input  logic [2:0]          cfg_parity,
    input  logic [1:0]          cfg_stop_bits,
    input  logic                cfg_invert,
    output logic                tx_line,
    output logic                tx_done
);

    frame_fmt_t         fmt;
    logic [FRAME_W-1:0] frame_word;
    logic [CNT_W-1:0]   frame_len;
    logic               busy;
    logic               tick;
    logic               accept;

    assign in_ready = !busy;
    assign accept   = in_valid && !busy;

    uft_cfg_decode u_decode (
        .raw_dbits  (cfg_data_bits),
        .raw_parity (cfg_parity),
        .raw_stop   (cfg_stop_bits),
        .raw_invert (cfg_invert),
        .fmt        (fmt)
    );

    uft_frame_builder u_build (
        .data (in_data),
        .fmt  (fmt),
        .word (frame_word),
        .len  (frame_len)
    );

    uft_bit_timer #(
        .PERIOD_W (PERIOD_W)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (accept),
        .period (bit_period),
        .busy   (busy),
        .tick   (tick)
    );

    uft_shifter u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (accept),
        .frame      (frame_word),
        .len        (frame_len),
        .tick       (tick),
        .idle_level (~cfg_invert),
        .tx         (tx_line),
        .busy       (busy),
        .done       (tx_done)
    );

    AST_START_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (tx_line == $past(cfg_invert))); // R1

    AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !in_ready); // R7

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |=> !tx_done); // R7

    AST_DONE_READY: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |-> in_ready); // R7

endmodule

// File: tb/sim_uart_frame_tx.sv
module sim_uart_frame_tx;

    localparam int PW = 16;

    typedef struct packed {
        logic [7:0] data;
        logic [3:0] dbits;
        logic [2:0] par;
        logic [1:0] stop;
        logic       inv;
        logic [3:0] period;
        logic [3:0] len;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{8'hA5, 4'd8, 3'd0, 2'd1, 1'b0, 4'd1, 4'd10},  // R1 plain 8N1
        '{8'hE1, 4'd5, 3'd1, 2'd2, 1'b0, 4'd2, 4'd9},   // R2 even over 5 bits, R3
        '{8'h3C, 4'd7, 3'd2, 2'd1, 1'b0, 4'd3, 4'd10},  // R2 odd
        '{8'h00, 4'd6, 3'd3, 2'd1, 1'b0, 4'd2, 4'd9},   // R2 mark
        '{8'hFF, 4'd8, 3'd4, 2'd2, 1'b0, 4'd1, 4'd12},  // R2 space, R3
        '{8'h5A, 4'd3, 3'd7, 2'd0, 1'b0, 4'd2, 4'd10},  // R1 R2 R3 defaults
        '{8'hC3, 4'd8, 3'd1, 2'd1, 1'b1, 4'd2, 4'd11},  // R4 invert
        '{8'h96, 4'd5, 3'd2, 2'd3, 1'b1, 4'd0, 4'd8},   // R4 R6 zero period
        '{8'h7E, 4'd7, 3'd3, 2'd2, 1'b0, 4'd4, 4'd11}   // R2 R3 mark two stop
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [7:0]    in_data = '0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [PW-1:0] bit_period = PW'(1);
    logic [3:0]    cfg_data_bits = 4'd8;
    logic [2:0]    cfg_parity = 3'd0;
    logic [1:0]    cfg_stop_bits = 2'd1;
    logic          cfg_invert = 1'b0;
    logic          tx_line;
    logic          tx_done;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    uart_frame_tx #(.PERIOD_W(PW)) u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .in_data       (in_data),
        .in_valid      (in_valid),
        .in_ready      (in_ready),
        .bit_period    (bit_period),
        .cfg_data_bits (cfg_data_bits),
        .cfg_parity    (cfg_parity),
        .cfg_stop_bits (cfg_stop_bits),
        .cfg_invert    (cfg_invert),
        .tx_line       (tx_line),
        .tx_done       (tx_done)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // Expected line value for bit k of a frame, from the requirements.
    function automatic logic exp_bit(vec_t v, int k);
        int d;
        logic [7:0] m;
        logic b;
        d = (v.dbits >= 4'd5 && v.dbits <= 4'd8) ? int'(v.dbits) : 8;
        m = 8'((1 << d) - 1);
        if (k == 0) b = 1'b0;
        else if (k <= d) b = v.data[k-1];
        else if (k == d + 1 && v.par >= 3'd1 && v.par <= 3'd4) begin
            case (v.par)
                3'd1:    b = ^(v.data & m);
                3'd2:    b = ~(^(v.data & m));
                3'd3:    b = 1'b1;
                default: b = 1'b0;
            endcase
        end else b = 1'b1;
        return b ^ v.inv;
    endfunction

    // Send one frame and check every cycle of it; optionally disturb inputs.
    task automatic run_frame(input vec_t v, input bit disturb);
        int p;
        int cyc;
        bit bad_bits;
        bit bad_ready;
        p = (v.period == 4'd0) ? 1 : int'(v.period);
        @(negedge clk);
        in_data       = v.data;
        cfg_data_bits = v.dbits;
        cfg_parity    = v.par;
        cfg_stop_bits = v.stop;
        cfg_invert    = v.inv;
        bit_period    = PW'(v.period);
        in_valid      = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = disturb;
        if (disturb) begin
            in_data       = ~v.data;
            cfg_data_bits = 4'd6;
            cfg_parity    = 3'd3;
            cfg_stop_bits = (v.stop == 2'd2) ? 2'd1 : 2'd2;
            bit_period    = PW'(7);
        end
        bad_bits  = 1'b0;
        bad_ready = 1'b0;
        cyc = 0;
        for (int k = 0; k < int'(v.len); k++) begin
            for (int c = 0; c < p; c++) begin
                if (tx_line !== exp_bit(v, k)) begin
                    if (!bad_bits)
                        $display("FAIL R1/R2/R3/R4/R6/R8: bit %0d cycle %0d actual %b expected %b",
                                 k, c, tx_line, exp_bit(v, k));
                    bad_bits = 1'b1;
                end
                if (in_ready !== 1'b0 || tx_done !== 1'b0) bad_ready = 1'b1;
                cyc++;
                @(negedge clk);
            end
        end
        n_checks++;
        if (bad_bits) n_fails++;
        check("R7 ready low and no done during frame", {31'd0, bad_ready}, 32'd0);
        check("R7 done pulse at frame end", {31'd0, tx_done}, 32'd1);
        check("R7 ready back at frame end", {31'd0, in_ready}, 32'd1);
        check("R7 line rests after frame", {31'd0, tx_line}, {31'd0, ~v.inv});
        in_valid = 1'b0;
        @(negedge clk);
        check("R7 done lasts one cycle", {31'd0, tx_done}, 32'd0);
    endtask

    initial begin
        // R9 reset state
        repeat (3) @(negedge clk);
        check("R9 tx in reset", {31'd0, tx_line}, 32'd1);
        check("R9 ready in reset", {31'd0, in_ready}, 32'd1);
        check("R9 done in reset", {31'd0, tx_done}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R9 tx after reset", {31'd0, tx_line}, 32'd1);
        check("R9 ready after reset", {31'd0, in_ready}, 32'd1);

        // Table walk: R1 R2 R3 R4 R6 R7
        for (int i = 0; i < NV; i++) begin
            run_frame(VECS[i], 1'b0);
        end

        // R8: inputs change and valid stays high during the frame
        run_frame(VECS[1], 1'b1);
        run_frame(VECS[6], 1'b1);

        // R5: idle level follows invert flag
        @(negedge clk);
        cfg_invert = 1'b1;
        @(negedge clk);
        check("R5 idle level inverted", {31'd0, tx_line}, 32'd0);
        cfg_invert = 1'b0;
        @(negedge clk);
        check("R5 idle level normal", {31'd0, tx_line}, 32'd1);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

endmodule